// File: doc/BRIEF.md
# March RAM Self-Test Engine

This block is a built-in test controller for a synchronous, 16-bit-wide RAM. Once started, it takes over the memory port and runs a fixed five-pass march over one address segment. It then repeats the whole march for every further segment until the full array has been covered. Two of the passes run in descending address order. Every pass after the first reads a location, checks the returned word against the value the previous pass left there, and overwrites it with the complement in the very next cycle.

Each mismatching read marks the bits that differ in a sticky per-bit failure vector. That vector is also folded onto a grid of memory devices, with a number of columns set by a parameter, so that a failing row or column of devices can be seen at a glance. When the last segment has finished, the engine raises done and holds it. It reports pass only if no bit ever failed.

The block has no data stream. Start, done and pass are plain level signals. The memory port is a fixed-timing synchronous interface with no back-pressure: the RAM must accept one access per cycle and return read data exactly one cycle after the read-enable cycle.

Top module: `mram_march_bist`

## Requirements
- R1: After reset the engine is idle: done, pass and every bit of fail_map, fail_rows and fail_cols are 0, and mem_we and mem_re are 0.
- R2: The first pass of each segment writes 0x0000 to one address per cycle, from local address 0 up to local address 2^ADDR_W-1, with mem_re low.
- R3: Each of passes 2 to 5 spends two cycles per address. In the first cycle mem_re is high and mem_we low. In the next cycle mem_we is high, mem_re is low and the address is the same. Pass 2 runs in descending order and writes 0xFFFF. Pass 3 runs in ascending order and writes 0x0000. Pass 4 runs in ascending order and writes 0xFFFF. Pass 5 runs in descending order and writes 0x0000.
- R4: mem_addr is {segment, local address}. The march is run for segment 0, then 1, and so on up to 2^SEG_W-1, each time with all five passes.
- R5: Read data is sampled in the write cycle that follows a read. It is compared with the value expected there: 0x0000 in passes 2 and 4, 0xFFFF in passes 3 and 5. Bit i of fail_map becomes 1 and stays 1 if data bit i ever mismatches.
- R6: done rises exactly 9·2^ADDR_W·2^SEG_W cycles after the edge that samples start, and stays high until the next start. pass equals done AND (fail_map == 0).
- R7: A start pulse while the march is running has no effect on the access sequence or on the time at which done rises.
- R8: A start while idle or done clears fail_map and begins a new march at segment 0.
- R9: While the engine is done or idle, mem_we and mem_re stay low.
- R10: fail_map bit i belongs to the device in row i / GRID_COLS and column i % GRID_COLS. fail_rows[r] is the OR of the bits in row r, and fail_cols[c] is the OR of the bits in column c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a new march when the engine is idle or done |
| done | output | 1 | High once the last segment has finished; held until the next start |
| pass | output | 1 | High when done and no bit failed |
| mem_addr | output | SEG_W+ADDR_W | Memory address: segment, then local address |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable; data is due one cycle later |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data returned one cycle after mem_re |
| fail_map | output | DATA_W | Sticky per-bit failure vector |
| fail_rows | output | DATA_W/GRID_COLS | Per-row OR of fail_map over the device grid |
| fail_cols | output | GRID_COLS | Per-column OR of fail_map over the device grid |

## Verification
The memory accesses are due in the cycle that follows the edge at which start is sampled. From then on, operation k appears on the port during the k-th cycle, so the bench computes the expected address, enables and data for each k arithmetically and compares them at every falling edge. done is due at the falling edge after 9·2^ADDR_W·2^SEG_W operations, and the bench checks that done is still low one cycle earlier. A read is answered by the bench memory one edge after mem_re, and the failure vector registers the result at the end of the write cycle. The bench therefore reads fail_map, the grid outputs and pass only once done is high, after injecting stuck-at faults of both polarities into every data bit and into every segment.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bist_state_e;

  // pass index 0 is the fill pass, 1..4 are read-verify-write passes
  localparam logic [2:0] PASS_FILL = 3'd0;
  localparam logic [2:0] PASS_LAST = 3'd4;

  function automatic logic pass_descending(input logic [2:0] p);
    return (p == 3'd1) || (p == 3'd4);
  endfunction

  function automatic logic pass_writes_ones(input logic [2:0] p);
    return (p == 3'd1) || (p == 3'd3);
  endfunction

  function automatic logic pass_expects_ones(input logic [2:0] p);
    return (p == 3'd2) || (p == 3'd4);
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import bist_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  output logic [SEG_W+ADDR_W-1:0] mem_addr_o,
  output logic                    mem_we_o,
  output logic                    mem_re_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic                    cmp_en_o,
  output logic                    cmp_ones_o,
  output logic                    clear_o,
  output logic                    done_o
);

  localparam logic [ADDR_W-1:0] IDX_LAST = '1;
  localparam logic [SEG_W-1:0]  SEG_LAST = '1;

  bist_state_e       state_q;
  logic [SEG_W-1:0]  seg_q;
  logic [2:0]        pass_q;
  logic [ADDR_W-1:0] idx_q;
  logic              phase_q;

  logic              running;
  logic              is_fill;
  logic              step_end;
  logic [ADDR_W-1:0] addr_loc;

  always_comb begin
    running     = (state_q == ST_RUN);
    is_fill     = (pass_q == PASS_FILL);
    step_end    = is_fill || phase_q;
    addr_loc    = pass_descending(pass_q) ? ~idx_q : idx_q;
    mem_addr_o  = {seg_q, addr_loc};
    mem_we_o    = running && (is_fill || phase_q);
    mem_re_o    = running && !is_fill && !phase_q;
    mem_wdata_o = pass_writes_ones(pass_q) ? '1 : '0;
    cmp_en_o    = running && !is_fill && phase_q;
    cmp_ones_o  = pass_expects_ones(pass_q);
    clear_o     = !running && start_i;
    done_o      = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      pass_q  <= PASS_FILL;
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else if (!running) begin
      if (start_i) begin
        state_q <= ST_RUN;
        seg_q   <= '0;
        pass_q  <= PASS_FILL;
        idx_q   <= '0;
        phase_q <= 1'b0;
      end
    end else if (!step_end) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= 1'b0;
      if (idx_q != IDX_LAST) begin
        idx_q <= idx_q + 1'b1;
      end else begin
        idx_q <= '0;
        if (pass_q != PASS_LAST) begin
          pass_q <= pass_q + 3'd1;
        end else begin
          pass_q <= PASS_FILL;
          if (seg_q != SEG_LAST) seg_q <= seg_q + 1'b1;
          else                   state_q <= ST_DONE;
        end
      end
    end
  end

  AST_NO_RD_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R3
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> (mem_we_o && mem_addr_o == $past(mem_addr_o))); // R3
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_we_o)); // R6
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(mem_we_o || mem_re_o)); // R9

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cmp_en_i,
  input  logic              cmp_ones_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] fail_o
);

  logic [DATA_W-1:0] fail_q;
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff   = rdata_i ^ (cmp_ones_i ? {DATA_W{1'b1}} : {DATA_W{1'b0}});
    fail_o = fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail_q <= '0;
    else if (clear_i)  fail_q <= '0;
    else if (cmp_en_i) fail_q <= fail_q | diff;
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((fail_q & $past(fail_q)) == $past(fail_q))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (fail_q == '0)); // R8

endmodule

// File: rtl/march_grid.sv
module march_grid #(
  parameter int DATA_W = 16,
  parameter int COLS   = 4
) (
  input  logic [DATA_W-1:0]      fail_i,
  output logic [DATA_W/COLS-1:0] rows_o,
  output logic [COLS-1:0]        cols_o
);

  localparam int ROWS = DATA_W / COLS;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rows_o[r] = |fail_i[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_cell
      assign col_bits[r] = fail_i[r*COLS + c];
    end
    assign cols_o[c] = |col_bits;
  end

  always_comb begin
    AST_GRID_CONSISTENT: assert ((|rows_o) == (|cols_o)); // R10
  end

endmodule

// File: rtl/mram_march_bist.sv
module mram_march_bist #(
  parameter int ADDR_W    = 16,
  parameter int SEG_W     = 2,
  parameter int DATA_W    = 16,
  parameter int GRID_COLS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           done,
  output logic                           pass,
  output logic [SEG_W+ADDR_W-1:0]        mem_addr,
  output logic                           mem_we,
  output logic                           mem_re,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic [DATA_W-1:0]              mem_rdata,
  output logic [DATA_W-1:0]              fail_map,
  output logic [DATA_W/GRID_COLS-1:0]    fail_rows,
  output logic [GRID_COLS-1:0]           fail_cols
);

  logic cmp_en;
  logic cmp_ones;
  logic clear;

  march_seq #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .mem_wdata_o (mem_wdata),
    .cmp_en_o    (cmp_en),
    .cmp_ones_o  (cmp_ones),
    .clear_o     (clear),
    .done_o      (done)
  );

  march_cmp #(.DATA_W(DATA_W)) i_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .cmp_en_i   (cmp_en),
    .cmp_ones_i (cmp_ones),
    .rdata_i    (mem_rdata),
    .fail_o     (fail_map)
  );

  march_grid #(.DATA_W(DATA_W), .COLS(GRID_COLS)) i_grid (
    .fail_i (fail_map),
    .rows_o (fail_rows),
    .cols_o (fail_cols)
  );

  assign pass = done && (fail_map == '0);

  AST_PASS_MEANS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && fail_map == '0)); // R6
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R6

endmodule

// File: tb/test_mram_march_bist.sv
module test_mram_march_bist;

  localparam int AW   = 4;
  localparam int SW   = 2;
  localparam int DW   = 16;
  localparam int COLS = 4;
  localparam int ROWS = DW / COLS;
  localparam int N    = 1 << AW;
  localparam int S    = 1 << SW;
  localparam int SEGC = 9 * N;
  localparam int T    = SEGC * S;
  localparam int MW   = AW + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, mem_we, mem_re;
  logic [MW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_map;
  logic [ROWS-1:0] fail_rows;
  logic [COLS-1:0] fail_cols;

  int tests = 0;
  int fails = 0;

  logic          fault_en = 1'b0;
  logic [MW-1:0] fault_addr = '0;
  logic [DW-1:0] fault_mask = '0;
  logic [DW-1:0] fault_val = '0;
  logic [DW-1:0] mem [0:(1<<MW)-1];

  always #10 clk = ~clk;

  mram_march_bist #(.ADDR_W(AW), .SEG_W(SW), .DATA_W(DW), .GRID_COLS(COLS)) i_mram_march_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fail_map(fail_map), .fail_rows(fail_rows), .fail_cols(fail_cols)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) begin
      if (fault_en && mem_addr == fault_addr)
        mem_rdata <= (mem[mem_addr] & ~fault_mask) | (fault_val & fault_mask);
      else
        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_op(input int t, output logic [MW-1:0] a, output logic we,
                           output logic re, output logic [DW-1:0] wd, output bit fill);
    int seg, r, q, p, i, loc;
    seg = t / SEGC;
    r   = t % SEGC;
    fill = (r < N);
    if (fill) begin
      loc = r; we = 1'b1; re = 1'b0; wd = '0;
    end else begin
      q = r - N;
      p = q / (2 * N) + 2;
      i = (q % (2 * N)) / 2;
      loc = (p == 2 || p == 5) ? (N - 1 - i) : i;
      re = ((q % 2) == 0);
      we = !re;
      wd = (p == 2 || p == 4) ? 16'hFFFF : 16'h0000;
    end
    a = MW'(seg * N + loc);
  endtask

  task automatic run_march(input bit trace, input bit poke_start);
    logic [MW-1:0] ea;
    logic ewe, ere;
    logic [DW-1:0] ewd;
    bit fill;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < T; k++) begin
      if (trace) begin
        expect_op(k, ea, ewe, ere, ewd, fill);
        if (fill) begin
          check(mem_addr == ea, "R2", "fill address", 32'(mem_addr), 32'(ea));
          check(mem_we && !mem_re, "R2", "fill enables", {mem_we, mem_re}, 2'b10);
          check(mem_wdata == 16'h0, "R2", "fill data", 32'(mem_wdata), 0);
        end else begin
          check(mem_addr == ea, "R3", "march address", 32'(mem_addr), 32'(ea));
          check(mem_we == ewe && mem_re == ere, "R3", "march enables",
                {mem_we, mem_re}, {ewe, ere});
          if (ewe) check(mem_wdata == ewd, "R3", "march data", 32'(mem_wdata), 32'(ewd));
        end
        if ((k % SEGC) == 0)
          check(mem_addr[MW-1:AW] == SW'(k / SEGC), "R4", "segment order",
                32'(mem_addr[MW-1:AW]), 32'(k / SEGC));
        if (k == T - 1) check(!done, "R6", "done early", 32'(done), 0);
      end
      if (poke_start && k == 100) start = 1'b1;
      if (poke_start && k == 101) start = 1'b0;
      @(negedge clk);
    end
    check(done, "R6", "done at latency", 32'(done), 1);
  endtask

  task automatic check_result(input logic [DW-1:0] exp_map, input string tag);
    logic [ROWS-1:0] er;
    logic [COLS-1:0] ec;
    er = '0; ec = '0;
    for (int b = 0; b < DW; b++) begin
      if (exp_map[b]) begin
        er[b / COLS] = 1'b1;
        ec[b % COLS] = 1'b1;
      end
    end
    check(fail_map == exp_map, "R5", {tag, " fail_map"}, 32'(fail_map), 32'(exp_map));
    check(pass == (exp_map == '0), "R6", {tag, " pass"}, 32'(pass), 32'(exp_map == '0));
    check(fail_rows == er && fail_cols == ec, "R10", {tag, " grid"},
          {fail_rows, fail_cols}, {er, ec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < (1 << MW); a++) mem[a] = 16'h5A5A;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && fail_map == 0 && fail_rows == 0 && fail_cols == 0,
          "R1", "reset outputs", {done, pass, fail_map}, 0);
    check(!mem_we && !mem_re, "R1", "reset enables", {mem_we, mem_re}, 0);

    // clean run with full access trace and a start pulse mid-run (R7)
    run_march(1'b1, 1'b1);
    check_result('0, "clean R7");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done && !mem_we && !mem_re, "R9", "quiet while done",
            {done, mem_we, mem_re}, 3'b100);
    end

    // single stuck bits of both polarities, swept over bits and segments
    for (int b = 0; b < DW; b++) begin
      fault_en   = 1'b1;
      fault_addr = MW'(b * 4 + 1);
      fault_mask = DW'(1) << b;
      fault_val  = (b % 2) ? '1 : '0;
      run_march(1'b0, 1'b0);
      check_result(fault_mask, (b % 2) ? "stuck1 R5" : "stuck0 R5");
    end

    // several bits in the last segment, spanning rows and columns
    fault_addr = MW'((S - 1) * N + N - 1);
    fault_mask = 16'h8421;
    fault_val  = 16'h0401;
    run_march(1'b0, 1'b0);
    check_result(16'h8421, "last segment R4");

    // restart without a fault clears the sticky map (R8)
    fault_en = 1'b0;
    run_march(1'b1, 1'b0);
    check_result('0, "restart R8");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule